// File: doc/BRIEF.md
# Vector Length Set Unit

This unit executes the instruction that configures a vector length. A request comes in on one strobe. It carries three mode flags, a 7-bit immediate, a 64-bit source operand value, the current 64-bit vector-state word, a destination register index and a record bit. One cycle later the unit returns three results: the updated vector-state word, an optional write of the new length to the destination register, and an optional 4-bit condition field.

The unit picks a maximum length and a requested length according to the mode flags, then clamps the request to the maximum. A clamp raises an overflow flag. The condition field is computed from the resulting length, not from the destination write. It is therefore produced even when the destination index is zero and nothing is written back, and its summary-overflow bit reports the clamp. One combination of flags asks for a step operation instead. That operation lives outside this unit, so the unit only raises a request strobe for it and writes nothing. Register-file ports and decode sit outside and connect through plain strobed ports.

Top module: `vlen_set_unit`

## Requirements
- R1: Every result is registered. `res_valid` rises in the cycle after a cycle with `req_valid` high. A synchronous active-low reset clears every output to zero.
- R2: The new maximum length is taken from the immediate or from the state word:
  - When `sel_max` is set, it is `len_imm`+1, saturated to 127.
  - When `sel_max` is clear, it is the maximum-length field of `vstate_in`. That field is bits [63:57] in LSB-0 numbering, which are MSB-0 bits 0..6.
- R3: The requested length depends on the flags:
  - With `sel_vec` set, it is `len_reg` when `len_from_reg` is set and `len_imm`+1 (unsaturated, up to 128) otherwise.
  - With `sel_vec` clear and `sel_max` set, it is the new maximum.
  - With both clear, it is the current-length field of `vstate_in`, bits [56:50].
- R4: The new length is the request clamped to the new maximum. The request is compared as an unsigned number. Overflow is flagged when the request exceeds the maximum; a request equal to the maximum is not an overflow.
- R5: Outside step mode, `vstate_out` is built from `vstate_in` as follows:
  - The maximum goes into [63:57] and the new length into [56:50].
  - The source-step field [49:43] and the destination-step field [42:36] are both zero.
  - Bits [35:1] pass through unchanged.
- R6: Bit [0] (vertical-first) takes `vert_first` when `sel_vec` or `sel_max` is set. Otherwise it keeps its input value.
- R7: With `vert_first` set and `sel_vec` and `sel_max` both clear, the unit enters step mode:
  - `step_req` pulses.
  - `vstate_out` equals `vstate_in`.
  - Neither `dest_we` nor `crf_we` is raised, whatever the index or record bit.
- R8: Outside step mode, `dest_we` is high exactly when `dest_idx` is nonzero. `dest_data` is the new 7-bit length with 57 zero bits above it.
- R9: Outside step mode, `crf_we` is high whenever `rec_en` is set, including when `dest_idx` is zero. `crf_out` holds {LT,GT,EQ,SO} in bits [3:0]:
  - LT, GT and EQ come from a signed comparison of the zero-extended 64-bit length against zero.
  - SO is the clamp overflow flag.
- R10: With `req_valid` low, the next cycle has `res_valid`, `step_req`, `dest_we` and `crf_we` all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Instruction strobe |
| sel_vec | input | 1 | Vector-length select flag |
| sel_max | input | 1 | Maximum-length select flag |
| vert_first | input | 1 | Vertical-first request flag |
| len_from_reg | input | 1 | Take requested length from the source operand |
| len_imm | input | 7 | Immediate (value minus one) |
| len_reg | input | 64 | Source operand value |
| vstate_in | input | 64 | Current vector-state word |
| dest_idx | input | 5 | Destination register index |
| rec_en | input | 1 | Record bit: update condition field |
| res_valid | output | 1 | Results valid |
| step_req | output | 1 | Step operation requested instead |
| vstate_out | output | 64 | Updated vector-state word |
| dest_we | output | 1 | Destination write enable |
| dest_idx_out | output | 5 | Destination register index |
| dest_data | output | 64 | Zero-extended new length |
| crf_we | output | 1 | Condition field write enable |
| crf_out | output | 4 | {LT,GT,EQ,SO} |

## Verification
The hardest case to reach is a condition-field update that has no destination write: the record bit is set, the index is zero and the request is clamped. The write port stays silent there, so only the condition field shows that the length was computed. The vector table drives exactly that case. It also drives a zero-length result from a zero operand, and a request whose top bit is set, which a signed compare would wrongly pass unclamped. Further entries reach the hold path: a current length that already exceeds the maximum, where overflow is flagged with no new request at all, and the saturating immediate of 127.

// File: rtl/vlset_pkg.sv
// Shared types for the vector length set unit.
// Assumes: a 4-bit condition field ordered LT,GT,EQ,SO from MSB to LSB.
package vlset_pkg;

    // Operating mode decoded from the three flags
    typedef enum logic [1:0] {
        MD_HOLD    = 2'd0,  // no flags: re-clamp the current length
        MD_MAXONLY = 2'd1,  // maximum select only: length follows new maximum
        MD_REQ     = 2'd2,  // vector select: explicit request
        MD_STEP    = 2'd3   // vertical-first alone: hand off to step logic
    } vl_mode_e;

    // Condition field layout
    typedef struct packed {
        logic lt;
        logic gt;
        logic eq;
        logic so;
    } crf_t;

endpackage

// File: rtl/vlset_mode_dec.sv
// Decodes the select flags into an operating mode.
// Assumes: vector select has priority over maximum select; step mode only
// when vertical-first is requested with neither select flag set.
module vlset_mode_dec
    import vlset_pkg::*;
(
    input  logic     sel_vec,
    input  logic     sel_max,
    input  logic     vert_first,
    output vl_mode_e mode
);

    // Priority decode of the flags
    always_comb begin
        if (sel_vec)         mode = MD_REQ;
        else if (sel_max)    mode = MD_MAXONLY;
        else if (vert_first) mode = MD_STEP;
        else                 mode = MD_HOLD;
    end

endmodule

// File: rtl/vlset_req_sel.sv
// Selects the new maximum length and the raw (unclamped) requested length.
// Assumes: the immediate encodes value minus one; the maximum saturates to
// the field's all-ones value, the request does not (so it can clamp).
module vlset_req_sel
    import vlset_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int LEN_W = 7
) (
    input  vl_mode_e          mode,
    input  logic              sel_max,
    input  logic              len_from_reg,
    input  logic [LEN_W-1:0]  len_imm,
    input  logic [XLEN-1:0]   len_reg,
    input  logic [LEN_W-1:0]  old_max,
    input  logic [LEN_W-1:0]  old_len,
    output logic [LEN_W-1:0]  new_max,
    output logic [XLEN-1:0]   request
);

    localparam int PAD_IMM = XLEN - LEN_W - 1;
    localparam int PAD_LEN = XLEN - LEN_W;

    logic [LEN_W:0]   imm_p1;
    logic [LEN_W-1:0] imm_sat;

    // Immediate plus one, one bit wider than the field
    assign imm_p1  = {1'b0, len_imm} + {{LEN_W{1'b0}}, 1'b1};
    // Saturate to the widest representable maximum
    assign imm_sat = imm_p1[LEN_W] ? {LEN_W{1'b1}} : imm_p1[LEN_W-1:0];

    // Maximum comes from the immediate or is kept
    always_comb begin
        new_max = sel_max ? imm_sat : old_max;
    end

    // Requested length per mode
    always_comb begin
        case (mode)
            MD_REQ:     request = len_from_reg ? len_reg
                                               : {{PAD_IMM{1'b0}}, imm_p1};
            MD_MAXONLY: request = {{PAD_LEN{1'b0}}, new_max};
            default:    request = {{PAD_LEN{1'b0}}, old_len};
        endcase
    end

endmodule

// File: rtl/vlset_clamp.sv
// Clamps an unsigned request to the maximum length and flags overflow.
// Assumes: the request is unsigned; equality with the maximum is no overflow.
module vlset_clamp #(
    parameter int XLEN  = 64,
    parameter int LEN_W = 7
) (
    input  logic [XLEN-1:0]  request,
    input  logic [LEN_W-1:0] max_len,
    output logic [LEN_W-1:0] length,
    output logic             overflow
);

    localparam int PAD = XLEN - LEN_W;

    // Unsigned compare and select
    always_comb begin
        overflow = request > {{PAD{1'b0}}, max_len};
        length   = overflow ? max_len : request[LEN_W-1:0];
    end

endmodule

// File: rtl/vlset_crgen.sv
// Builds the condition field from a result value and an overflow flag.
// Assumes: a signed comparison against zero; exactly one of LT/GT/EQ set.
module vlset_crgen
    import vlset_pkg::*;
#(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] value,
    input  logic            so_in,
    output crf_t            crf
);

    // Signed compare against zero
    always_comb begin
        crf.lt = $signed(value) < $signed({XLEN{1'b0}});
        crf.gt = $signed(value) > $signed({XLEN{1'b0}});
        crf.eq = (value == {XLEN{1'b0}});
        crf.so = so_in;
    end

endmodule

// File: rtl/vlen_set_unit.sv
// Single-cycle vector length set execution unit.
// Assumes: state word holds maximum length in its top LEN_W bits, current
// length below it, then source-step and destination-step fields, and the
// vertical-first flag in bit 0; all results registered one cycle after the
// request strobe; synchronous active-low reset.
module vlen_set_unit
    import vlset_pkg::*;
#(
    parameter int XLEN  = 64,
    parameter int LEN_W = 7,
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             sel_vec,
    input  logic             sel_max,
    input  logic             vert_first,
    input  logic             len_from_reg,
    input  logic [LEN_W-1:0] len_imm,
    input  logic [XLEN-1:0]  len_reg,
    input  logic [XLEN-1:0]  vstate_in,
    input  logic [IDX_W-1:0] dest_idx,
    input  logic             rec_en,
    output logic             res_valid,
    output logic             step_req,
    output logic [XLEN-1:0]  vstate_out,
    output logic             dest_we,
    output logic [IDX_W-1:0] dest_idx_out,
    output logic [XLEN-1:0]  dest_data,
    output logic             crf_we,
    output logic [3:0]       crf_out
);

    // Field positions in the state word
    localparam int MAX_HI = XLEN - 1;
    localparam int MAX_LO = XLEN - LEN_W;
    localparam int LEN_HI = MAX_LO - 1;
    localparam int LEN_LO = XLEN - 2 * LEN_W;
    localparam int SRC_HI = LEN_LO - 1;
    localparam int SRC_LO = XLEN - 3 * LEN_W;
    localparam int DST_HI = SRC_LO - 1;
    localparam int DST_LO = XLEN - 4 * LEN_W;
    localparam int VF_BIT = 0;
    localparam int PAD    = XLEN - LEN_W;

    vl_mode_e         mode;
    logic [LEN_W-1:0] new_max;
    logic [XLEN-1:0]  request;
    logic [LEN_W-1:0] new_len;
    logic             ovf;
    logic [XLEN-1:0]  len_ext;
    crf_t             crf_n;
    logic [XLEN-1:0]  state_n;
    logic             is_step;

    vlset_mode_dec u_dec (
        .sel_vec    (sel_vec),
        .sel_max    (sel_max),
        .vert_first (vert_first),
        .mode       (mode)
    );

    vlset_req_sel #(.XLEN(XLEN), .LEN_W(LEN_W)) u_sel (
        .mode         (mode),
        .sel_max      (sel_max),
        .len_from_reg (len_from_reg),
        .len_imm      (len_imm),
        .len_reg      (len_reg),
        .old_max      (vstate_in[MAX_HI:MAX_LO]),
        .old_len      (vstate_in[LEN_HI:LEN_LO]),
        .new_max      (new_max),
        .request      (request)
    );

    vlset_clamp #(.XLEN(XLEN), .LEN_W(LEN_W)) u_clamp (
        .request  (request),
        .max_len  (new_max),
        .length   (new_len),
        .overflow (ovf)
    );

    assign len_ext = {{PAD{1'b0}}, new_len};

    vlset_crgen #(.XLEN(XLEN)) u_cr (
        .value (len_ext),
        .so_in (ovf),
        .crf   (crf_n)
    );

    assign is_step = (mode == MD_STEP);

    // Assemble the next state word
    always_comb begin
        state_n = vstate_in;
        if (!is_step) begin
            state_n[MAX_HI:MAX_LO] = new_max;
            state_n[LEN_HI:LEN_LO] = new_len;
            state_n[SRC_HI:SRC_LO] = '0;
            state_n[DST_HI:DST_LO] = '0;
            if (sel_vec || sel_max) state_n[VF_BIT] = vert_first;
        end
    end

    // Strobe registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            step_req  <= 1'b0;
            dest_we   <= 1'b0;
            crf_we    <= 1'b0;
        end else begin
            res_valid <= req_valid;
            step_req  <= req_valid && is_step;
            dest_we   <= req_valid && !is_step && (dest_idx != '0);
            crf_we    <= req_valid && !is_step && rec_en;
        end
    end

    // Data registers, loaded on each request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vstate_out   <= '0;
            dest_idx_out <= '0;
            dest_data    <= '0;
            crf_out      <= '0;
        end else if (req_valid) begin
            vstate_out   <= state_n;
            dest_idx_out <= dest_idx;
            dest_data    <= len_ext;
            crf_out      <= crf_n;
        end
    end

    // ---------------- assertions ----------------
    p_valid_next_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> res_valid);

    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!res_valid && !step_req && !dest_we && !crf_we));

    p_len_le_max_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !step_req) |->
            (vstate_out[LEN_HI:LEN_LO] <= vstate_out[MAX_HI:MAX_LO]));

    p_steps_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !step_req) |->
            (vstate_out[SRC_HI:SRC_LO] == '0 && vstate_out[DST_HI:DST_LO] == '0));

    p_step_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        step_req |-> (!dest_we && !crf_we && res_valid));

    p_step_state_r7: assert property (@(posedge clk) disable iff (!rst_n)
        step_req |-> (vstate_out == $past(vstate_in)));

    p_dest_zext_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dest_we |-> (dest_data == {{PAD{1'b0}}, vstate_out[LEN_HI:LEN_LO]}
                     && dest_idx_out != '0));

    p_cr_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        crf_we |-> ($countones(crf_out[3:1]) == 1));

    p_so_at_max_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (crf_we && crf_out[0]) |->
            (vstate_out[LEN_HI:LEN_LO] == vstate_out[MAX_HI:MAX_LO]));

endmodule

// File: tb/vlen_set_unit_bench.sv
`timescale 1ns/1ps
module vlen_set_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        sel_vec = 1'b0, sel_max = 1'b0, vert_first = 1'b0;
    logic        len_from_reg = 1'b0;
    logic [6:0]  len_imm = '0;
    logic [63:0] len_reg = '0;
    logic [63:0] vstate_in = '0;
    logic [4:0]  dest_idx = '0;
    logic        rec_en = 1'b0;
    logic        res_valid, step_req, dest_we, crf_we;
    logic [63:0] vstate_out, dest_data;
    logic [4:0]  dest_idx_out;
    logic [3:0]  crf_out;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    localparam logic [34:0] FILL = 35'h2_A5A5_A5A5;

    always #2 clk = ~clk;

    vlen_set_unit u_vlen_set_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
        .sel_vec(sel_vec), .sel_max(sel_max), .vert_first(vert_first),
        .len_from_reg(len_from_reg), .len_imm(len_imm), .len_reg(len_reg),
        .vstate_in(vstate_in), .dest_idx(dest_idx), .rec_en(rec_en),
        .res_valid(res_valid), .step_req(step_req), .vstate_out(vstate_out),
        .dest_we(dest_we), .dest_idx_out(dest_idx_out), .dest_data(dest_data),
        .crf_we(crf_we), .crf_out(crf_out)
    );

    typedef struct packed {
        logic        vs, ms, vf, ureg;
        logic [6:0]  imm;
        logic [63:0] src;
        logic [6:0]  o_max, o_len;
        logic        o_vf;
        logic [4:0]  idx;
        logic        rc;
        logic [6:0]  e_max, e_len;
        logic        e_vf, e_step;
        logic [3:0]  e_cr;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{1'b1,1'b0,1'b0,1'b1, 7'd0,   64'd127,   7'd5,7'd3,1'b0, 5'd0, 1'b1, 7'd5,  7'd5,  1'b0,1'b0,4'b0101},
        '{1'b1,1'b0,1'b0,1'b1, 7'd0,   64'd4,     7'd5,7'd3,1'b0, 5'd3, 1'b1, 7'd5,  7'd4,  1'b0,1'b0,4'b0100},
        '{1'b1,1'b0,1'b0,1'b1, 7'd0,   64'd0,     7'd5,7'd3,1'b1, 5'd7, 1'b1, 7'd5,  7'd0,  1'b0,1'b0,4'b0010},
        '{1'b1,1'b0,1'b1,1'b0, 7'd2,   64'd0,     7'd5,7'd0,1'b0, 5'd1, 1'b0, 7'd5,  7'd3,  1'b1,1'b0,4'b0100},
        '{1'b1,1'b0,1'b0,1'b0, 7'd0,   64'd0,     7'd5,7'd3,1'b1, 5'd0, 1'b0, 7'd5,  7'd1,  1'b0,1'b0,4'b0100},
        '{1'b0,1'b1,1'b0,1'b0, 7'd9,   64'd0,     7'd5,7'd3,1'b1, 5'd2, 1'b1, 7'd10, 7'd10, 1'b0,1'b0,4'b0100},
        '{1'b1,1'b1,1'b0,1'b1, 7'd15,  64'h1_0000_0000, 7'd5,7'd3,1'b0, 5'd31,1'b1, 7'd16, 7'd16, 1'b0,1'b0,4'b0101},
        '{1'b1,1'b1,1'b0,1'b0, 7'd127, 64'd0,     7'd5,7'd3,1'b0, 5'd9, 1'b1, 7'd127,7'd127,1'b0,1'b0,4'b0101},
        '{1'b0,1'b0,1'b0,1'b0, 7'd0,   64'd0,     7'd5,7'd3,1'b1, 5'd4, 1'b1, 7'd5,  7'd3,  1'b1,1'b0,4'b0100},
        '{1'b0,1'b0,1'b1,1'b0, 7'd0,   64'd0,     7'd5,7'd3,1'b0, 5'd5, 1'b1, 7'd5,  7'd3,  1'b0,1'b1,4'b0000},
        '{1'b1,1'b0,1'b0,1'b1, 7'd0,   64'd5,     7'd5,7'd3,1'b0, 5'd6, 1'b1, 7'd5,  7'd5,  1'b0,1'b0,4'b0100},
        '{1'b1,1'b0,1'b0,1'b1, 7'd0,   64'd6,     7'd5,7'd3,1'b0, 5'd6, 1'b1, 7'd5,  7'd5,  1'b0,1'b0,4'b0101},
        '{1'b0,1'b0,1'b0,1'b0, 7'd0,   64'd0,     7'd5,7'd9,1'b0, 5'd8, 1'b1, 7'd5,  7'd5,  1'b0,1'b0,4'b0101},
        '{1'b1,1'b0,1'b0,1'b1, 7'd0,   64'h8000_0000_0000_0000, 7'd100,7'd3,1'b0, 5'd0, 1'b1, 7'd100,7'd100,1'b0,1'b0,4'b0101}
    };

    function automatic logic [63:0] mk_state(logic [6:0] mx, logic [6:0] ln,
                                             logic [6:0] ss, logic [6:0] ds,
                                             logic vf);
        return {mx, ln, ss, ds, FILL, vf};
    endfunction

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic apply(vec_t v);
        sel_vec = v.vs; sel_max = v.ms; vert_first = v.vf; len_from_reg = v.ureg;
        len_imm = v.imm; len_reg = v.src; dest_idx = v.idx; rec_en = v.rc;
        vstate_in = mk_state(v.o_max, v.o_len, 7'd11, 7'd22, v.o_vf);
        req_valid = 1'b1;
    endtask

    // Checks the registered results of vector v (called at a negedge)
    task automatic check_vec(vec_t v, int n);
        logic [63:0] exp_state;
        logic        exp_dwe, exp_cwe;
        exp_state = v.e_step ? mk_state(v.o_max, v.o_len, 7'd11, 7'd22, v.o_vf)
                             : mk_state(v.e_max, v.e_len, 7'd0, 7'd0, v.e_vf);
        exp_dwe = !v.e_step && (v.idx != 5'd0);
        exp_cwe = !v.e_step && v.rc;
        chk("R1", $sformatf("vec%0d valid", n), {63'd0, res_valid}, 64'd1);
        chk("R5", $sformatf("vec%0d state (R2 R3 R4 R6)", n), vstate_out, exp_state);
        chk("R7", $sformatf("vec%0d step", n), {63'd0, step_req}, {63'd0, v.e_step});
        chk("R8", $sformatf("vec%0d dest_we", n), {63'd0, dest_we}, {63'd0, exp_dwe});
        if (exp_dwe) begin
            chk("R8", $sformatf("vec%0d dest_data", n), dest_data, {57'd0, v.e_len});
            chk("R8", $sformatf("vec%0d dest_idx", n), {59'd0, dest_idx_out}, {59'd0, v.idx});
        end
        chk("R9", $sformatf("vec%0d crf_we", n), {63'd0, crf_we}, {63'd0, exp_cwe});
        if (exp_cwe)
            chk("R9", $sformatf("vec%0d crf", n), {60'd0, crf_out}, {60'd0, v.e_cr});
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "reset valid", {63'd0, res_valid}, 64'd0);
        chk("R1", "reset state", vstate_out, 64'd0);
        chk("R1", "reset strobes", {60'd0, step_req, dest_we, crf_we, 1'b0}, 64'd0);
        chk("R1", "reset crf", {60'd0, crf_out}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            apply(VECS[i]);
            @(negedge clk);
            req_valid = 1'b0;
            check_vec(VECS[i], i);
        end

        // R10: idle cycle with record and index set keeps all strobes low
        sel_vec = 1'b1; rec_en = 1'b1; dest_idx = 5'd3; req_valid = 1'b0;
        @(negedge clk);
        chk("R10", "idle strobes",
            {60'd0, res_valid, step_req, dest_we, crf_we}, 64'd0);

        // R1: back-to-back requests each produce results in the next cycle
        apply(VECS[1]);
        @(negedge clk);
        check_vec(VECS[1], 101);
        apply(VECS[0]);
        @(negedge clk);
        req_valid = 1'b0;
        check_vec(VECS[0], 100);

        // R1: reset during a request clears the outputs
        apply(VECS[5]);
        rst_n = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R1", "mid reset valid", {63'd0, res_valid}, 64'd0);
        chk("R1", "mid reset state", vstate_out, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule